// File: doc/BRIEF.md
# Move-Addressed 8-bit ALU Function Unit

This unit is the arithmetic and logic resource of a processor whose only instruction is a move from a source address to a destination address. A move that names one of the unit's two destination addresses loads operand A or operand B. A move that names one of the unit's source addresses reads a result. Every result is a separate address: sum, difference, their carry and borrow flags, the carry-chained forms, the bitwise functions, the shifts and the bits they push out, the product halves, quotient, remainder and six unsigned comparisons. No opcode exists.

The unit keeps a small amount of state besides the two operands. A stored carry feeds the carry-chained add and subtract sources. Two rolled-off registers capture the bits pushed out by the most recent left shift and by the most recent right shift. A read strobe qualifies each read. Only a qualified read of certain sources changes this state, so reading the same address twice in a row can give different values. The unit is always ready. A write is taken on every cycle its enable is high, and a read returns its data combinationally in the cycle of the strobe. No back-pressure exists on either side.

Top module: `mv_alu_unit`

## Requirements
- R1: A synchronous active-high reset clears operand A, operand B, the stored carry and both rolled-off registers to zero.
- R2: When `a_we` (or `b_we`) is high at a clock edge, operand A (or B) takes `wr_data`; otherwise it holds. Source code 0 reads A and code 1 reads B.
- R3: When `rd_en` is low, `rd_data` is 0. Unassigned source codes 25 to 31 read as 0.
- R4: Code 2 gives (A+B) mod 256 and code 3 gives its carry-out as 0 or 1. Code 5 gives (A-B) mod 256 and code 6 gives 1 when A<B, else 0.
- R5: Code 4 gives (A+B+c) mod 256 and code 7 gives (A-B-c) mod 256, where c is the stored carry. The stored carry is updated only by a strobed read of these codes. A read of code 2 stores the carry of A+B. A read of code 4 stores the carry of A+B+c. A read of code 5 stores the borrow A<B. A read of code 7 stores the borrow A<B+c. Any other cycle leaves the carry unchanged.
- R6: Codes 8, 9 and 10 give A AND B, A OR B and A XOR B.
- R7: Code 11 gives A shifted left by B bit places. Code 12 gives A shifted right logically by B places. Both are 0 when B is 8 or more.
- R8: A strobed read of code 11 stores the bits pushed out of the top, right-aligned, which is bits 15:8 of the 16-bit value A·2^B (0 when B≥16). A strobed read of code 12 stores the bits pushed out of the bottom, left-aligned, which is bits 7:0 of (A·256)>>B. Codes 13 and 14 read these two registers. Each register changes only on its own shift read.
- R9: Codes 15 and 16 give the low and high bytes of the unsigned 16-bit product A·B.
- R10: Codes 17 and 18 give the unsigned quotient and remainder of A/B. When B is 0 the quotient is 8'hFF and the remainder is A.
- R11: Codes 19 to 24 give the unsigned comparisons A==B, A>B, A>=B, A!=B, A<B and A<=B, in that order, as 8'h01 for true and 8'h00 for false.
- R12: A read in the same cycle as an operand write sees the operand values from before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_data | input | 8 | Data moved into an operand register |
| a_we | input | 1 | Load operand A from wr_data |
| b_we | input | 1 | Load operand B from wr_data |
| src_sel | input | 5 | Source address being read |
| rd_en | input | 1 | Read strobe; qualifies the read and its side effects |
| rd_data | output | 8 | Value of the selected source, 0 when rd_en is low |

## Verification
The bench targets the stateful corners. If the stored carry were updated by a flag read, or by an unstrobed cycle, the carry-chained results would drift away from the model. If a rolled-off register were loaded whenever its shift was selected, instead of only on a strobed read, a later read of codes 13 and 14 would return the wrong bits. Shift amounts of 8 to 15 and of 16 or more are driven on purpose. A shifter that wrapped the amount, or that lost the pushed-out bits past eight places, would return nonzero results where zero is required. The bench also drives division by zero, where a design without the special case would give an undefined quotient. It checks reads in the same cycle as writes, where a design that forwarded the new operand would show the written byte one cycle early. It applies a reset in the middle of the run, after which any state that was not cleared shows up in the next reads.

// File: rtl/mv_alu_pkg.sv
package mv_alu_pkg;
  localparam int SEL_W = 5;

  typedef enum logic [SEL_W-1:0] {
    SRC_OPA    = 5'd0,
    SRC_OPB    = 5'd1,
    SRC_SUM    = 5'd2,
    SRC_SUM_CY = 5'd3,
    SRC_ADC    = 5'd4,
    SRC_DIF    = 5'd5,
    SRC_DIF_BW = 5'd6,
    SRC_SBC    = 5'd7,
    SRC_AND    = 5'd8,
    SRC_OR     = 5'd9,
    SRC_XOR    = 5'd10,
    SRC_SHL    = 5'd11,
    SRC_SHR    = 5'd12,
    SRC_SHL_PO = 5'd13,
    SRC_SHR_PO = 5'd14,
    SRC_MUL_LO = 5'd15,
    SRC_MUL_HI = 5'd16,
    SRC_QUO    = 5'd17,
    SRC_REM    = 5'd18,
    SRC_EQ     = 5'd19,
    SRC_GT     = 5'd20,
    SRC_GE     = 5'd21,
    SRC_NE     = 5'd22,
    SRC_LT     = 5'd23,
    SRC_LE     = 5'd24
  } src_e;
endpackage

// File: rtl/mv_alu_opregs.sv
module mv_alu_opregs #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] wr_data,
  input  logic          a_we,
  input  logic          b_we,
  output logic [DW-1:0] opa,
  output logic [DW-1:0] opb
);
  localparam int NREG = 2;

  logic [NREG-1:0]         we_vec;
  logic [DW-1:0]           regs [NREG];

  assign we_vec = {b_we, a_we};

  for (genvar i = 0; i < NREG; i++) begin : g_opreg
    always_ff @(posedge clk) begin
      if (rst) begin
        regs[i] <= '0;
      end else if (we_vec[i]) begin
        regs[i] <= wr_data;
      end
    end
  end

  assign opa = regs[0];
  assign opb = regs[1];

  // R2: operands hold when not written, load when written
  p_opa_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !a_we |=> $stable(opa));
  p_opb_load_r2: assert property (@(posedge clk) disable iff (rst)
    b_we |=> (opb == $past(wr_data)));
endmodule

// File: rtl/mv_alu_arith.sv
module mv_alu_arith #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          cin,
  output logic [DW-1:0] sum,
  output logic          sum_co,
  output logic [DW-1:0] adc,
  output logic          adc_co,
  output logic [DW-1:0] dif,
  output logic          dif_bo,
  output logic [DW-1:0] sbc,
  output logic          sbc_bo,
  output logic [DW-1:0] and_v,
  output logic [DW-1:0] or_v,
  output logic [DW-1:0] xor_v,
  output logic [DW-1:0] mul_lo,
  output logic [DW-1:0] mul_hi,
  output logic [DW-1:0] quo,
  output logic [DW-1:0] rem,
  output logic          eq,
  output logic          gt,
  output logic          lt
);
  localparam int XW = DW + 1;
  localparam int PW = 2 * DW;

  logic [XW-1:0] add_x, adc_x, sub_x, sbc_x;
  logic [XW-1:0] cin_x;
  logic [PW-1:0] prod;

  always_comb begin
    cin_x = {{DW{1'b0}}, cin};
    add_x = {1'b0, a} + {1'b0, b};
    adc_x = {1'b0, a} + {1'b0, b} + cin_x;
    sub_x = {1'b0, a} - {1'b0, b};
    sbc_x = {1'b0, a} - {1'b0, b} - cin_x;
  end

  assign sum    = add_x[DW-1:0];
  assign sum_co = add_x[DW];
  assign adc    = adc_x[DW-1:0];
  assign adc_co = adc_x[DW];
  assign dif    = sub_x[DW-1:0];
  assign dif_bo = sub_x[DW];
  assign sbc    = sbc_x[DW-1:0];
  assign sbc_bo = sbc_x[DW];

  assign and_v = a & b;
  assign or_v  = a | b;
  assign xor_v = a ^ b;

  assign prod   = PW'(a) * PW'(b);
  assign mul_lo = prod[DW-1:0];
  assign mul_hi = prod[PW-1:DW];

  always_comb begin
    if (b == '0) begin
      quo = '1;
      rem = a;
    end else begin
      quo = a / b;
      rem = a % b;
    end
  end

  assign eq = (a == b);
  assign gt = (a > b);
  assign lt = (a < b);

  // R11: exactly one ordering relation holds
  p_cmp_one_r11: assert property (@(posedge clk) disable iff (rst)
    $countones({eq, gt, lt}) == 1);
  // R10: nonzero divisor reconstructs the dividend
  p_div_ok_r10: assert property (@(posedge clk) disable iff (rst)
    (b != '0) |-> ((PW'(quo) * PW'(b) + PW'(rem)) == PW'(a) && rem < b));
  // R4: borrow flag agrees with the ordering
  p_borrow_r4: assert property (@(posedge clk) disable iff (rst)
    dif_bo == lt);
endmodule

// File: rtl/mv_alu_shift.sv
module mv_alu_shift #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          rd_shl,
  input  logic          rd_shr,
  output logic [DW-1:0] shl,
  output logic [DW-1:0] shr,
  output logic [DW-1:0] shl_po,
  output logic [DW-1:0] shr_po
);
  localparam int EW = 2 * DW;

  logic [EW-1:0] l_ext, r_ext;
  logic [DW-1:0] l_lost, r_lost;

  always_comb begin
    l_ext = {{DW{1'b0}}, a} << b;
    r_ext = {a, {DW{1'b0}}} >> b;
  end

  assign shl    = l_ext[DW-1:0];
  assign l_lost = l_ext[EW-1:DW];
  assign shr    = r_ext[EW-1:DW];
  assign r_lost = r_ext[DW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      shl_po <= '0;
      shr_po <= '0;
    end else begin
      if (rd_shl) shl_po <= l_lost;
      if (rd_shr) shr_po <= r_lost;
    end
  end

  // R8: pushed-out registers change only on their own shift read
  p_lpo_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !rd_shl |=> $stable(shl_po));
  p_rpo_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !rd_shr |=> $stable(shr_po));
  // R7: over-wide shift amounts give zero
  p_wide_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (b >= DW[DW-1:0]) |-> (shl == '0 && shr == '0));
endmodule

// File: rtl/mv_alu_unit.sv
module mv_alu_unit
  import mv_alu_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DW-1:0]    wr_data,
  input  logic             a_we,
  input  logic             b_we,
  input  logic [SEL_W-1:0] src_sel,
  input  logic             rd_en,
  output logic [DW-1:0]    rd_data
);
  localparam logic [DW-1:0] TRUE_V  = DW'(1);
  localparam logic [DW-1:0] FALSE_V = '0;

  src_e sel;
  assign sel = src_e'(src_sel);

  logic [DW-1:0] opa, opb;
  logic          carry_q;

  logic [DW-1:0] sum, adc, dif, sbc, and_v, or_v, xor_v;
  logic [DW-1:0] mul_lo, mul_hi, quo, rem;
  logic          sum_co, adc_co, dif_bo, sbc_bo, eq, gt, lt;
  logic [DW-1:0] shl, shr, shl_po, shr_po;

  mv_alu_opregs #(.DW(DW)) u_opregs (
    .clk(clk), .rst(rst), .wr_data(wr_data),
    .a_we(a_we), .b_we(b_we), .opa(opa), .opb(opb)
  );

  mv_alu_arith #(.DW(DW)) u_arith (
    .clk(clk), .rst(rst), .a(opa), .b(opb), .cin(carry_q),
    .sum(sum), .sum_co(sum_co), .adc(adc), .adc_co(adc_co),
    .dif(dif), .dif_bo(dif_bo), .sbc(sbc), .sbc_bo(sbc_bo),
    .and_v(and_v), .or_v(or_v), .xor_v(xor_v),
    .mul_lo(mul_lo), .mul_hi(mul_hi), .quo(quo), .rem(rem),
    .eq(eq), .gt(gt), .lt(lt)
  );

  logic rd_shl, rd_shr;
  assign rd_shl = rd_en && (sel == SRC_SHL);
  assign rd_shr = rd_en && (sel == SRC_SHR);

  mv_alu_shift #(.DW(DW)) u_shift (
    .clk(clk), .rst(rst), .a(opa), .b(opb),
    .rd_shl(rd_shl), .rd_shr(rd_shr),
    .shl(shl), .shr(shr), .shl_po(shl_po), .shr_po(shr_po)
  );

  // stored carry: written only by strobed arithmetic result reads
  logic carry_touch;
  logic carry_nxt;

  always_comb begin
    carry_touch = 1'b0;
    carry_nxt   = carry_q;
    if (rd_en) begin
      unique case (sel)
        SRC_SUM: begin carry_touch = 1'b1; carry_nxt = sum_co; end
        SRC_ADC: begin carry_touch = 1'b1; carry_nxt = adc_co; end
        SRC_DIF: begin carry_touch = 1'b1; carry_nxt = dif_bo; end
        SRC_SBC: begin carry_touch = 1'b1; carry_nxt = sbc_bo; end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) carry_q <= 1'b0;
    else     carry_q <= carry_nxt;
  end

  function automatic logic [DW-1:0] flag(input logic f);
    return f ? TRUE_V : FALSE_V;
  endfunction

  logic [DW-1:0] mux_v;

  always_comb begin
    unique case (sel)
      SRC_OPA:    mux_v = opa;
      SRC_OPB:    mux_v = opb;
      SRC_SUM:    mux_v = sum;
      SRC_SUM_CY: mux_v = flag(sum_co);
      SRC_ADC:    mux_v = adc;
      SRC_DIF:    mux_v = dif;
      SRC_DIF_BW: mux_v = flag(dif_bo);
      SRC_SBC:    mux_v = sbc;
      SRC_AND:    mux_v = and_v;
      SRC_OR:     mux_v = or_v;
      SRC_XOR:    mux_v = xor_v;
      SRC_SHL:    mux_v = shl;
      SRC_SHR:    mux_v = shr;
      SRC_SHL_PO: mux_v = shl_po;
      SRC_SHR_PO: mux_v = shr_po;
      SRC_MUL_LO: mux_v = mul_lo;
      SRC_MUL_HI: mux_v = mul_hi;
      SRC_QUO:    mux_v = quo;
      SRC_REM:    mux_v = rem;
      SRC_EQ:     mux_v = flag(eq);
      SRC_GT:     mux_v = flag(gt);
      SRC_GE:     mux_v = flag(!lt);
      SRC_NE:     mux_v = flag(!eq);
      SRC_LT:     mux_v = flag(lt);
      SRC_LE:     mux_v = flag(!gt);
      default:    mux_v = '0;
    endcase
  end

  assign rd_data = rd_en ? mux_v : '0;

  // R5: carry holds on every cycle without a qualifying read
  p_carry_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !carry_touch |=> $stable(carry_q));
  // R1: state is clear in the cycle after reset
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (opa == '0 && opb == '0 && !carry_q && shl_po == '0 && shr_po == '0));
endmodule

// File: tb/mv_alu_unit_tb.sv
module mv_alu_unit_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] wr_data = '0;
  logic       a_we = 1'b0;
  logic       b_we = 1'b0;
  logic [4:0] src_sel = '0;
  logic       rd_en = 1'b0;
  logic [7:0] rd_data;

  int checks = 0;
  int failures = 0;

  // behavioural model state
  int ma = 0, mb = 0, mc = 0, mlp = 0, mrp = 0;

  always #5 clk = ~clk;

  mv_alu_unit u_dut (
    .clk(clk), .rst(rst), .wr_data(wr_data), .a_we(a_we), .b_we(b_we),
    .src_sel(src_sel), .rd_en(rd_en), .rd_data(rd_data)
  );

  function automatic int model_read(input int s);
    case (s)
      0:  return ma;
      1:  return mb;
      2:  return (ma + mb) % 256;
      3:  return (ma + mb > 255) ? 1 : 0;
      4:  return (ma + mb + mc) % 256;
      5:  return (ma - mb + 256) % 256;
      6:  return (ma < mb) ? 1 : 0;
      7:  return (ma - mb - mc + 512) % 256;
      8:  return ma & mb;
      9:  return ma | mb;
      10: return ma ^ mb;
      11: return (mb >= 8) ? 0 : (ma * (1 << mb)) % 256;
      12: return (mb >= 8) ? 0 : ma / (1 << mb);
      13: return mlp;
      14: return mrp;
      15: return (ma * mb) % 256;
      16: return (ma * mb) / 256;
      17: return (mb == 0) ? 255 : ma / mb;
      18: return (mb == 0) ? ma : ma % mb;
      19: return (ma == mb) ? 1 : 0;
      20: return (ma > mb) ? 1 : 0;
      21: return (ma >= mb) ? 1 : 0;
      22: return (ma != mb) ? 1 : 0;
      23: return (ma < mb) ? 1 : 0;
      24: return (ma <= mb) ? 1 : 0;
      default: return 0;
    endcase
  endfunction

  function automatic string req_of(input int s);
    if (s <= 1) return "R2";
    if (s == 4 || s == 7) return "R5";
    if (s <= 7) return "R4";
    if (s <= 10) return "R6";
    if (s <= 12) return "R7";
    if (s <= 14) return "R8";
    if (s <= 16) return "R9";
    if (s <= 18) return "R10";
    if (s <= 24) return "R11";
    return "R3";
  endfunction

  task automatic step(input bit wa, input bit wb, input int d, input int s,
                      input bit rd, input string tag);
    int exp;
    string t;
    @(negedge clk);
    a_we = wa; b_we = wb; wr_data = d[7:0]; src_sel = s[4:0]; rd_en = rd;
    #1;
    exp = rd ? model_read(s) : 0;
    t = (tag != "") ? tag : (rd ? req_of(s) : "R3");
    checks++;
    if (rd_data !== exp[7:0]) begin
      failures++;
      $display("FAIL %s sel=%0d actual=%02h expected=%02h", t, s, rd_data, exp[7:0]);
    end
    @(posedge clk);
    if (rd) begin
      case (s)
        2:  mc = (ma + mb > 255) ? 1 : 0;
        4:  mc = (ma + mb + mc > 255) ? 1 : 0;
        5:  mc = (ma < mb) ? 1 : 0;
        7:  mc = (ma < mb + mc) ? 1 : 0;
        11: mlp = (mb >= 16) ? 0 : ((ma * (1 << mb)) / 256) % 256;
        12: mrp = (mb >= 16) ? 0 : ((ma * 256) / (1 << mb)) % 256;
        default: ;
      endcase
    end
    if (wa) ma = d % 256;
    if (wb) mb = d % 256;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; a_we = 0; b_we = 0; rd_en = 0;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    ma = 0; mb = 0; mc = 0; mlp = 0; mrp = 0;
  endtask

  task automatic load(input int a, input int b);
    step(1, 1, a, 0, 0, "R2");
    step(0, 1, b, 0, 0, "R2");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset values
    step(0, 0, 0, 0, 1, "R1");
    step(0, 0, 0, 13, 1, "R1");
    step(0, 0, 0, 14, 1, "R1");
    step(0, 0, 0, 4, 1, "R1");
    // sweep of every code with nontrivial operands
    load(8'hF0, 8'h23);
    for (int s = 0; s < 32; s++) step(0, 0, 0, s, 1, "");
    load(8'h23, 8'hF0);
    for (int s = 0; s < 32; s++) step(0, 0, 0, s, 1, "");
    // R10: divide by zero
    load(8'h9C, 0);
    step(0, 0, 0, 17, 1, "R10");
    step(0, 0, 0, 18, 1, "R10");
    // R11: equal operands
    load(8'h44, 8'h44);
    for (int s = 19; s <= 24; s++) step(0, 0, 0, s, 1, "R11");
    // R7/R8: shift amounts in range, 8..15, and >=16
    for (int amt = 0; amt < 20; amt += 3) begin
      load(8'hB5, amt);
      step(0, 0, 0, 11, 1, "R7");
      step(0, 0, 0, 12, 1, "R7");
      step(0, 0, 0, 13, 1, "R8");
      step(0, 0, 0, 14, 1, "R8");
    end
    // R8: selecting a shift without strobe leaves pushed-out bits alone
    load(8'hFF, 4);
    step(0, 0, 0, 11, 0, "R8");
    step(0, 0, 0, 12, 0, "R8");
    step(0, 0, 0, 13, 1, "R8");
    step(0, 0, 0, 14, 1, "R8");
    // R5: carry chain, flag reads and unstrobed reads do not touch carry
    load(8'hFF, 8'h01);
    step(0, 0, 0, 2, 1, "R5");
    step(0, 0, 0, 4, 1, "R5");
    step(0, 0, 0, 3, 1, "R5");
    step(0, 0, 0, 7, 1, "R5");
    load(8'h10, 8'h20);
    step(0, 0, 0, 5, 0, "R5");
    step(0, 0, 0, 4, 1, "R5");
    step(0, 0, 0, 5, 1, "R5");
    step(0, 0, 0, 6, 1, "R5");
    step(0, 0, 0, 7, 1, "R5");
    step(0, 0, 0, 4, 1, "R5");
    // R3: idle strobe and unused codes
    step(0, 0, 0, 2, 0, "R3");
    step(0, 0, 0, 27, 1, "R3");
    step(0, 0, 0, 31, 1, "R3");
    // R12: read during write sees old value
    step(1, 0, 8'h5A, 0, 1, "R12");
    step(0, 1, 8'hA5, 1, 1, "R12");
    step(0, 0, 0, 0, 1, "R12");
    step(0, 0, 0, 1, 1, "R12");
    // random traffic
    for (int i = 0; i < 4000; i++) begin
      int d, s;
      bit wa, wb, rd;
      wa = ($urandom % 5) == 0;
      wb = ($urandom % 5) == 0;
      rd = ($urandom % 5) != 0;
      s  = $urandom % 32;
      d  = $urandom % 256;
      if (wb && ($urandom % 2 == 0)) d = $urandom % 20;
      step(wa, wb, d, s, rd, "");
    end
    // R1: reset in mid-run after nonzero state
    load(8'hC3, 8'h05);
    step(0, 0, 0, 11, 1, "");
    step(0, 0, 0, 12, 1, "");
    step(0, 0, 0, 5, 1, "");
    do_reset();
    step(0, 0, 0, 0, 1, "R1");
    step(0, 0, 0, 1, 1, "R1");
    step(0, 0, 0, 13, 1, "R1");
    step(0, 0, 0, 14, 1, "R1");
    step(0, 0, 0, 7, 1, "R1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule